// File: doc/BRIEF.md
# Refresh Interval Timer with Keyed Register Writes

This block paces memory refresh. An 8-bit up-counter advances on ticks from a prescaler that divides the input clock by a selectable power of two. Each time a tick finds the counter equal to an 8-bit compare constant, three things happen. The counter returns to zero, a one-cycle refresh request is issued, and a sticky compare flag is set. An interrupt follows the flag when its enable bit is set.

Software reaches three registers over a simple 16-bit bus: the control/status word, the counter and the compare constant. A write only lands when it is a full 16-bit write and its upper byte holds the key 8'hA5. Any other write is dropped, which guards the timer against stray stores.

The compare flag cannot be cleared by a plain write. Software first writes 0 to the flag. The flag then clears when the next refresh completes while refresh is enabled and the plain (CBR) refresh mode is selected. Only the power-on reset clears the registers. The manual reset restarts the prescaler phase only, and standby freezes counting.

Top module: `refresh_timer`

## Requirements
- R1: Power-on reset `por` (synchronous, active high) clears the control word, counter, compare constant, read data, `ref_req` and `irq` to zero.
- R2: A write is accepted only when `bus_wr` and `bus_full` are both 1 and `bus_wdata[15:8]` is 8'hA5. The register is chosen by `bus_addr`: 0 selects the control word, 1 the counter, 2 the compare constant. Data comes from `bus_wdata[7:0]`. Any other write changes nothing.
- R3: `bus_rdata` returns the register selected by `bus_addr` one cycle later. Bits 15:8 always read 0, and address 3 reads 0.
- R4: The control word holds these fields: bit 7 compare flag, bit 6 compare interrupt enable, bits 5:3 clock select, bit 2 overflow flag, bit 1 overflow interrupt enable, bit 0 limit select. Clock select 0 stops the counter. Codes 1 to 7 advance it once every 4, 16, 64, 256, 1024, 2048 and 4096 clocks respectively.
- R5: A tick that finds the counter equal to the compare constant does three things at that edge. It loads the counter with 0, sets the compare flag, and drives `ref_req` high for exactly one cycle. The period between requests is therefore (constant+1) times the divide ratio.
- R6: Writing 1 to the compare flag bit leaves the flag unchanged.
- R7: The compare flag clears only on a `ref_done` pulse that meets all of these conditions: it comes while `ref_en`=1 and `ref_mode`=0, and a keyed write of 0 to the flag has happened since the flag was last set. A done pulse with `ref_mode`=1, with `ref_en`=0, or without that prior write leaves the flag set.
- R8: `irq` is 1 exactly when the compare flag and the compare interrupt enable are both 1. It is registered together with them.
- R9: Registers keep their values across `mrst`, which only restarts the prescaler. While `stby` is 1 the prescaler and counter hold still.
- R10: A compare event in the same cycle as a clearing refresh completion leaves the flag set.
- R11: A keyed counter write in the same cycle as a tick loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| mrst | input | 1 | Manual reset: restarts the prescaler only |
| stby | input | 1 | Standby: freezes prescaler and counter |
| bus_wr | input | 1 | Write strobe |
| bus_full | input | 1 | Write covers all 16 bits |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rdata | output | 16 | Registered read data |
| ref_en | input | 1 | Refresh enabled |
| ref_mode | input | 1 | Refresh mode, 0 = CBR |
| ref_done | input | 1 | Refresh completed pulse |
| ref_req | output | 1 | One-cycle refresh request |
| irq | output | 1 | Compare interrupt request |

## Verification
The bench builds the block with its default 8-bit counter and the full 12-bit prescaler. At these values every divide ratio can be reached by a real measurement, including the longest, 4096 clocks with a compare constant of 0. A behavioural model tracks the prescaler phase, so the bench can place a refresh completion or a counter write exactly on the cycle of a tick or a compare event. That timing brings the same-cycle priority cases within reach.

// File: rtl/rft_pkg.sv
package rft_pkg;
  localparam logic [7:0] WR_KEY = 8'hA5;

  typedef enum logic [1:0] {
    A_CSR  = 2'd0,
    A_CNT  = 2'd1,
    A_CMP  = 2'd2,
    A_NONE = 2'd3
  } rft_addr_e;

  typedef struct packed {
    logic       cmf;
    logic       cmie;
    logic [2:0] cks;
    logic       ovf;
    logic       ovie;
    logic       lmts;
  } rft_csr_t;

  // log2 of the divide ratio for each clock-select code (0 = stopped)
  function automatic int unsigned div_shift(input int unsigned code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      5: return 10;
      6: return 11;
      7: return 12;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/rft_prescaler.sv
module rft_prescaler
  import rft_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  logic       mrst,
  input  logic       stby,
  input  logic [2:0] sel,
  output logic       tick_o
);
  localparam int PSC_W = div_shift(7);
  localparam int NSEL  = 8;

  logic [PSC_W-1:0] psc_q;
  logic [NSEL-1:0]  tap;

  always_ff @(posedge clk) begin
    if (por || mrst)  psc_q <= '0;
    else if (!stby)   psc_q <= psc_q + PSC_W'(1);
  end

  assign tap[0] = 1'b0;
  for (genvar c = 1; c < NSEL; c++) begin : g_tap
    localparam int SH = div_shift(c);
    assign tap[c] = &psc_q[SH-1:0];
  end

  assign tick_o = tap[sel] && !stby && !mrst;

  // R9
  psc_hold_chk: assert property (@(posedge clk) disable iff (por)
    (stby && !mrst) |=> $stable(psc_q));
  // R9
  psc_restart_chk: assert property (@(posedge clk) disable iff (por)
    mrst |=> (psc_q == '0));
endmodule

// File: rtl/rft_interval_cnt.sv
module rft_interval_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             por,
  input  logic             tick_i,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             match_o
);
  assign match_o = tick_i && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (por)          cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wdata;
    else if (match_o) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (por)         cmp_q <= '0;
    else if (cmp_wr) cmp_q <= wdata;
  end

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (por)
    (match_o && !cnt_wr) |=> (cnt_q == '0));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (por)
    (!tick_i && !cnt_wr) |=> $stable(cnt_q));
  // R11
  wr_wins_chk: assert property (@(posedge clk) disable iff (por)
    cnt_wr |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/rft_ctrl.sv
module rft_ctrl
  import rft_pkg::*;
(
  input  logic     clk,
  input  logic     por,
  input  logic     csr_wr,
  input  rft_csr_t wdata,
  input  logic     match_i,
  input  logic     ref_en,
  input  logic     ref_mode,
  input  logic     ref_done,
  output rft_csr_t csr_q,
  output logic     irq_q,
  output logic     ref_req_q
);
  logic     arm_q, arm_n, done_clr;
  rft_csr_t csr_n;

  assign done_clr = ref_done && ref_en && !ref_mode && arm_q;

  always_comb begin
    csr_n = csr_q;
    arm_n = arm_q;
    if (done_clr) begin
      csr_n.cmf = 1'b0;
      arm_n     = 1'b0;
    end
    if (csr_wr) begin
      csr_n.cmie = wdata.cmie;
      csr_n.cks  = wdata.cks;
      csr_n.ovf  = wdata.ovf;
      csr_n.ovie = wdata.ovie;
      csr_n.lmts = wdata.lmts;
      if (!wdata.cmf) arm_n = 1'b1;
    end
    if (match_i) begin
      csr_n.cmf = 1'b1;
      arm_n     = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      csr_q     <= '0;
      arm_q     <= 1'b0;
      irq_q     <= 1'b0;
      ref_req_q <= 1'b0;
    end else begin
      csr_q     <= csr_n;
      arm_q     <= arm_n;
      irq_q     <= csr_n.cmf && csr_n.cmie;
      ref_req_q <= match_i;
    end
  end

  // R6
  flag_set_src_chk: assert property (@(posedge clk) disable iff (por)
    $rose(csr_q.cmf) |-> $past(match_i));
  // R7
  flag_clr_src_chk: assert property (@(posedge clk) disable iff (por)
    $fell(csr_q.cmf) |-> $past(ref_done && ref_en && !ref_mode));
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (por)
    match_i |=> csr_q.cmf);
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (por)
    irq_q == (csr_q.cmf && csr_q.cmie));
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rft_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        por,
  input  logic        mrst,
  input  logic        stby,
  input  logic        bus_wr,
  input  logic        bus_full,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        ref_en,
  input  logic        ref_mode,
  input  logic        ref_done,
  output logic        ref_req,
  output logic        irq
);
  localparam int DW = 16;

  logic             key_ok, csr_wr, cnt_wr, cmp_wr, tick, match;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  rft_csr_t         csr_q;
  rft_addr_e        addr;

  assign addr   = rft_addr_e'(bus_addr);
  assign key_ok = bus_wr && bus_full && (bus_wdata[15:8] == WR_KEY);
  assign csr_wr = key_ok && (addr == A_CSR);
  assign cnt_wr = key_ok && (addr == A_CNT);
  assign cmp_wr = key_ok && (addr == A_CMP);

  rft_prescaler u_psc (
    .clk    (clk),
    .por    (por),
    .mrst   (mrst),
    .stby   (stby),
    .sel    (csr_q.cks),
    .tick_o (tick)
  );

  rft_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .por     (por),
    .tick_i  (tick),
    .cnt_wr  (cnt_wr),
    .cmp_wr  (cmp_wr),
    .wdata   (bus_wdata[CNT_W-1:0]),
    .cnt_q   (cnt_q),
    .cmp_q   (cmp_q),
    .match_o (match)
  );

  rft_ctrl u_ctrl (
    .clk       (clk),
    .por       (por),
    .csr_wr    (csr_wr),
    .wdata     (rft_csr_t'(bus_wdata[7:0])),
    .match_i   (match),
    .ref_en    (ref_en),
    .ref_mode  (ref_mode),
    .ref_done  (ref_done),
    .csr_q     (csr_q),
    .irq_q     (irq),
    .ref_req_q (ref_req)
  );

  always_ff @(posedge clk) begin
    if (por) bus_rdata <= '0;
    else begin
      case (addr)
        A_CSR:   bus_rdata <= DW'(csr_q);
        A_CNT:   bus_rdata <= DW'(cnt_q);
        A_CMP:   bus_rdata <= DW'(cmp_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (por)
    ref_req |=> !ref_req);
  // R2
  unkeyed_cmp_chk: assert property (@(posedge clk) disable iff (por)
    !cmp_wr |=> $stable(cmp_q));
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (por)
    $past(bus_addr) == 2'd3 |-> bus_rdata == 16'h0000);
endmodule

// File: tb/test_refresh_timer.sv
module test_refresh_timer;
  logic        clk = 1'b0;
  logic        por = 1'b1, mrst = 1'b0, stby = 1'b0;
  logic        bus_wr = 1'b0, bus_full = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        ref_en = 1'b0, ref_mode = 1'b0, ref_done = 1'b0;
  logic        ref_req, irq;

  int n_chk = 0, n_fail = 0;

  refresh_timer i_refresh_timer (
    .clk(clk), .por(por), .mrst(mrst), .stby(stby),
    .bus_wr(bus_wr), .bus_full(bus_full), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_en(ref_en), .ref_mode(ref_mode), .ref_done(ref_done),
    .ref_req(ref_req), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_psc, m_cnt, m_cmp, m_cks;
  bit m_flag, m_arm, m_ie, m_ovf, m_ovie, m_lmts, m_req, m_irq, m_live;
  int m_rd;

  function automatic int ratio(input int code);
    int r;
    r = 1;
    case (code)
      1: r = 4;    2: r = 16;   3: r = 64;   4: r = 256;
      5: r = 1024; 6: r = 2048; 7: r = 4096; default: r = 1;
    endcase
    return r;
  endfunction

  function automatic bit pred_tick();
    return (m_cks != 0) && ((m_psc % ratio(m_cks)) == ratio(m_cks) - 1);
  endfunction

  function automatic bit pred_match();
    return pred_tick() && (m_cnt == m_cmp);
  endfunction

  function automatic int csr_val();
    return {m_flag, m_ie, m_cks[2:0], m_ovf, m_ovie, m_lmts};
  endfunction

  always @(posedge clk) begin : model
    bit tk, mt, key, done_clr;
    if (por) begin
      m_psc = 0; m_cnt = 0; m_cmp = 0; m_cks = 0;
      m_flag = 0; m_arm = 0; m_ie = 0; m_ovf = 0; m_ovie = 0; m_lmts = 0;
      m_req = 0; m_irq = 0; m_rd = 0; m_live = 1;
    end else begin
      tk  = !mrst && !stby && pred_tick();
      mt  = tk && (m_cnt == m_cmp);
      key = bus_wr && bus_full && (bus_wdata[15:8] == 8'hA5);
      done_clr = ref_done && ref_en && !ref_mode && m_arm;
      case (bus_addr)
        2'd0: m_rd = csr_val();
        2'd1: m_rd = m_cnt;
        2'd2: m_rd = m_cmp;
        default: m_rd = 0;
      endcase
      m_psc = mrst ? 0 : (stby ? m_psc : (m_psc + 1) % 4096);
      if (key && bus_addr == 2'd1) m_cnt = bus_wdata[7:0];
      else if (mt) m_cnt = 0;
      else if (tk) m_cnt = (m_cnt + 1) % 256;
      if (key && bus_addr == 2'd2) m_cmp = bus_wdata[7:0];
      if (done_clr) begin m_flag = 0; m_arm = 0; end
      if (key && bus_addr == 2'd0) begin
        m_ie = bus_wdata[6]; m_cks = int'(bus_wdata[5:3]);
        m_ovf = bus_wdata[2]; m_ovie = bus_wdata[1]; m_lmts = bus_wdata[0];
        if (!bus_wdata[7]) m_arm = 1;
      end
      if (mt) begin m_flag = 1; m_arm = 0; end
      m_req = mt;
      m_irq = m_flag && m_ie;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_live && !por) begin
      chk("R5 ref_req", int'(ref_req), int'(m_req));
      chk("R8 irq", int'(irq), int'(m_irq));
      chk("R3 rdata", int'(bus_rdata), m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic full);
    @(negedge clk);
    bus_wr = 1'b1; bus_full = full; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_full = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic done_pulse(input logic en, input logic mode);
    @(negedge clk);
    ref_en = en; ref_mode = mode; ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
  endtask

  task automatic measure(input int code, input int cval, input string tag);
    int n;
    wr(2'd0, 16'hA500, 1'b1);
    wr(2'd1, 16'hA500, 1'b1);
    wr(2'd2, 16'hA500 | 16'(cval), 1'b1);
    wr(2'd0, 16'hA500 | 16'(code << 3), 1'b1);
    while (!ref_req) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_req);
    chk(tag, n, (cval + 1) * ratio(code));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int v, w;
    repeat (3) @(negedge clk);
    por = 1'b0;
    // R1 reset state
    rd(2'd0, v); chk("R1 csr", v, 0);
    rd(2'd1, v); chk("R1 cnt", v, 0);
    rd(2'd2, v); chk("R1 cmp", v, 0);
    chk("R1 ref_req", int'(ref_req), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 keyed writes
    wr(2'd2, 16'h0003, 1'b1); rd(2'd2, v); chk("R2 no key", v, 0);
    wr(2'd2, 16'h5A03, 1'b1); rd(2'd2, v); chk("R2 bad key", v, 0);
    wr(2'd2, 16'hA503, 1'b0); rd(2'd2, v); chk("R2 partial", v, 0);
    wr(2'd2, 16'hA503, 1'b1); rd(2'd2, v); chk("R2 keyed", v, 3);

    // R6 writing 1 to the flag, R3 upper byte reads 0
    wr(2'd0, 16'hA5FF, 1'b1); rd(2'd0, v);
    chk("R6 flag write1", v, 16'h007F);
    chk("R3 upper byte", v >> 8, 0);
    rd(2'd3, v); chk("R3 unused addr", v, 0);
    wr(2'd0, 16'hA500, 1'b1);

    // R4 stopped counter and divide ratios
    wr(2'd1, 16'hA505, 1'b1);
    repeat (50) @(negedge clk);
    rd(2'd1, v); chk("R4 stopped", v, 5);
    measure(1, 3, "R4 div4");
    measure(2, 1, "R4 div16");
    measure(5, 1, "R4 div1024");
    measure(7, 0, "R4 div4096");

    // R5 / R8 compare event with interrupt
    wr(2'd0, 16'hA500, 1'b1);
    wr(2'd1, 16'hA500, 1'b1);
    wr(2'd2, 16'hA502, 1'b1);
    wr(2'd0, 16'hA548, 1'b1);
    while (!ref_req) @(negedge clk);
    chk("R8 irq on flag", int'(irq), 1);
    rd(2'd0, v); chk("R5 flag set", v & 16'h80, 16'h80);

    // R7 clearing rules
    wr(2'd0, 16'hA5C0, 1'b1);
    repeat (2) @(negedge clk);
    done_pulse(1'b1, 1'b0);
    rd(2'd0, v); chk("R7 no prior write", v, 16'h00C0);
    wr(2'd0, 16'hA540, 1'b1);
    rd(2'd0, v); chk("R7 write0 alone", v, 16'h00C0);
    done_pulse(1'b1, 1'b1);
    rd(2'd0, v); chk("R7 mode1", v, 16'h00C0);
    done_pulse(1'b0, 1'b0);
    rd(2'd0, v); chk("R7 en0", v, 16'h00C0);
    done_pulse(1'b1, 1'b0);
    rd(2'd0, v); chk("R7 cleared", v, 16'h0040);
    chk("R8 irq off", int'(irq), 0);

    // R9 manual reset and standby
    @(negedge clk); mrst = 1'b1; @(negedge clk); mrst = 1'b0;
    rd(2'd0, v); chk("R9 csr kept", v, 16'h0040);
    rd(2'd2, v); chk("R9 cmp kept", v, 2);
    wr(2'd0, 16'hA548, 1'b1);
    @(negedge clk); stby = 1'b1;
    rd(2'd1, v);
    repeat (30) @(negedge clk);
    rd(2'd1, w); chk("R9 standby hold", w, v);
    @(negedge clk); stby = 1'b0;

    // R10 compare event beats a clearing completion
    wr(2'd0, 16'hA540, 1'b1);
    wr(2'd0, 16'hA548, 1'b1);
    @(negedge clk);
    while (!pred_match()) @(negedge clk);
    ref_en = 1'b1; ref_mode = 1'b0; ref_done = 1'b1;
    @(negedge clk); ref_done = 1'b0;
    chk("R10 irq kept", int'(irq), 1);
    rd(2'd0, v); chk("R10 flag kept", v & 16'h80, 16'h80);

    // R11 counter write on a tick
    @(negedge clk);
    while (!pred_tick()) @(negedge clk);
    bus_wr = 1'b1; bus_full = 1'b1; bus_addr = 2'd1; bus_wdata = 16'hA540;
    @(negedge clk); bus_wr = 1'b0; bus_full = 1'b0;
    v = int'(bus_rdata);
    @(negedge clk); v = int'(bus_rdata);
    chk("R11 write wins", v, 16'h0040);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule